// File: doc/BRIEF.md
# Register Swap Sequencer

This block exchanges the contents of two data registers, A and B, by moving values through a third scratch register over a shared bus. After a start request it runs three single-register transfers, one per clock cycle: B goes to scratch, then A goes to B, then scratch goes to A. During each transfer it raises exactly one bus-drive enable and one capture enable. In the last transfer it also raises `done`, and it then returns to rest.

The three registers and the bus multiplexer are part of the block, so the effect of each control step can be seen directly. A preload port lets the surrounding logic, or a bench, place values into any register while the sequencer is at rest. A parameter selects one of two state encodings: a two-bit binary code, or a one-flop-per-transfer code in which rest is the all-zero pattern. The behaviour at the ports is the same for both encodings.

Top module: `reg_swap_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), all enables and `done` are 0, `bus` is 0, all three registers read 0, and the sequencer is at rest.
- R2: At rest, a clock edge with `start` = 0 keeps the sequencer at rest, with every enable and `done` at 0.
- R3: A clock edge at rest with `start` = 1 enters the first transfer. In that cycle `b_drive` and `s_capture` are 1, and the edge that ends the cycle copies B into scratch.
- R4: The cycle after the first transfer is always the second transfer. In it `a_drive` and `b_capture` are 1, and the edge that ends it copies A into B.
- R5: The cycle after the second transfer is always the third transfer. In it `s_drive`, `a_capture` and `done` are 1, and the edge that ends it copies scratch into A. `done` is 1 in no other state.
- R6: After the third transfer the sequencer always returns to rest for at least one cycle, whatever `start` is. If `start` is held at 1, the swap repeats every 4 cycles.
- R7: `bus` carries the value of the register whose drive enable is 1. When no drive enable is 1, `bus` is 0.
- R8: In any cycle, at most one drive enable and at most one capture enable is 1. The enables depend only on the present state.
- R9: At rest, `pre_en` = 1 writes `pre_data` at the clock edge into the register chosen by `pre_sel` (1 = A, 2 = B, 3 = scratch; 0 writes nothing). While a transfer is in progress, `pre_en` has no effect.
- R10: The `ONE_HOT` parameter (0 = binary code, 1 = one flop per transfer) leaves the port behaviour unchanged, cycle for cycle.
- R11: A reset asserted in the middle of a swap stops it at once. After release, the sequencer starts from rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Swap request, sampled at rest |
| pre_en | input | 1 | Preload strobe, honoured at rest only |
| pre_sel | input | 2 | Preload target: 1 = A, 2 = B, 3 = scratch |
| pre_data | input | DATA_W | Preload value |
| a_drive | output | 1 | Register A drives the bus |
| a_capture | output | 1 | Register A loads from the bus |
| b_drive | output | 1 | Register B drives the bus |
| b_capture | output | 1 | Register B loads from the bus |
| s_drive | output | 1 | Scratch register drives the bus |
| s_capture | output | 1 | Scratch register loads from the bus |
| done | output | 1 | High in the final transfer cycle |
| bus | output | DATA_W | Shared transfer bus |
| a_q | output | DATA_W | Register A contents |
| b_q | output | DATA_W | Register B contents |
| s_q | output | DATA_W | Scratch register contents |

## Verification
The enables, `done` and `bus` for a transfer are valid in the cycle after the edge that sampled `start` or ended the previous transfer. The register effect of a transfer appears only after the edge that ends it, so a full swap is complete three edges after `start` was seen. The bench drives its inputs just after a rising edge and samples every output one time unit after the next rising edge. Each vector therefore holds the state and register contents that exactly one edge produced. The asynchronous reset is the only result checked in the middle of a cycle, a short time after `rst_n` falls.

// File: rtl/swap_pkg.sv
package swap_pkg;

   localparam int NUM_REGS = 3;
   localparam int SEL_W    = 2;

   localparam int IDX_A = 0;
   localparam int IDX_B = 1;
   localparam int IDX_S = 2;

   typedef enum logic [1:0] {
      PH_REST   = 2'd0,
      PH_B_TO_S = 2'd1,
      PH_A_TO_B = 2'd2,
      PH_S_TO_A = 2'd3
   } swap_phase_e;

   typedef struct packed {
      logic a_drive;
      logic a_capture;
      logic b_drive;
      logic b_capture;
      logic s_drive;
      logic s_capture;
      logic done;
   } swap_ctl_t;

   localparam swap_ctl_t CTL_NONE = '0;

   function automatic logic [NUM_REGS-1:0] drive_vec(input swap_ctl_t c);
      logic [NUM_REGS-1:0] v;
      v        = '0;
      v[IDX_A] = c.a_drive;
      v[IDX_B] = c.b_drive;
      v[IDX_S] = c.s_drive;
      return v;
   endfunction

   function automatic logic [NUM_REGS-1:0] capture_vec(input swap_ctl_t c);
      logic [NUM_REGS-1:0] v;
      v        = '0;
      v[IDX_A] = c.a_capture;
      v[IDX_B] = c.b_capture;
      v[IDX_S] = c.s_capture;
      return v;
   endfunction

endpackage

// File: rtl/swap_state_reg.sv
module swap_state_reg
   import swap_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output swap_ctl_t ctl,
   output logic      at_rest
);

   generate
      if (ONE_HOT) begin : g_onehot
         // one flop per transfer; rest is the all-zero pattern so reset clears every flop
         localparam int HOT_W = 3;
         logic [HOT_W-1:0] hot_q;
         logic [HOT_W-1:0] hot_d;
         logic             rest_w;

         assign rest_w = ~|hot_q;

         always_comb begin
            hot_d    = '0;
            hot_d[0] = rest_w & start;
            hot_d[1] = hot_q[0];
            hot_d[2] = hot_q[1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hot_q <= '0;
            else        hot_q <= hot_d;
         end

         always_comb begin
            ctl           = CTL_NONE;
            ctl.b_drive   = hot_q[0];
            ctl.s_capture = hot_q[0];
            ctl.a_drive   = hot_q[1];
            ctl.b_capture = hot_q[1];
            ctl.s_drive   = hot_q[2];
            ctl.a_capture = hot_q[2];
            ctl.done      = hot_q[2];
         end

         assign at_rest = rest_w;
      end else begin : g_binary
         swap_phase_e ph_q;
         swap_phase_e ph_d;

         always_comb begin
            case (ph_q)
               PH_REST:   ph_d = start ? PH_B_TO_S : PH_REST;
               PH_B_TO_S: ph_d = PH_A_TO_B;
               PH_A_TO_B: ph_d = PH_S_TO_A;
               PH_S_TO_A: ph_d = PH_REST;
               default:   ph_d = PH_REST;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= PH_REST;
            else        ph_q <= ph_d;
         end

         always_comb begin
            ctl = CTL_NONE;
            case (ph_q)
               PH_B_TO_S: begin
                  ctl.b_drive   = 1'b1;
                  ctl.s_capture = 1'b1;
               end
               PH_A_TO_B: begin
                  ctl.a_drive   = 1'b1;
                  ctl.b_capture = 1'b1;
               end
               PH_S_TO_A: begin
                  ctl.s_drive   = 1'b1;
                  ctl.a_capture = 1'b1;
                  ctl.done      = 1'b1;
               end
               default: ctl = CTL_NONE;
            endcase
         end

         assign at_rest = (ph_q == PH_REST);
      end
   endgenerate

endmodule

// File: rtl/swap_bus_mux.sv
module swap_bus_mux #(
   parameter int DATA_W   = 8,
   parameter int NUM_SRC  = 3
) (
   input  logic [NUM_SRC-1:0][DATA_W-1:0] src,
   input  logic [NUM_SRC-1:0]             drive,
   output logic [DATA_W-1:0]              bus
);

   // AND-OR selection: zero when nothing drives
   logic [NUM_SRC-1:0][DATA_W-1:0] gated;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
         assign gated[g] = src[g] & {DATA_W{drive[g]}};
      end
   endgenerate

   always_comb begin
      bus = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         bus = bus | gated[k];
      end
   end

endmodule

// File: rtl/swap_regfile.sv
module swap_regfile #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [DATA_W-1:0]               bus,
   input  logic [NUM_REGS-1:0]             capture,
   input  logic [NUM_REGS-1:0]             preload,
   input  logic [DATA_W-1:0]               pre_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0] q
);

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[g] <= '0;
            end else if (capture[g]) begin
               q[g] <= bus;
            end else if (preload[g]) begin
               q[g] <= pre_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/reg_swap_ctrl.sv
module reg_swap_ctrl
   import swap_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit ONE_HOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              pre_en,
   input  logic [1:0]        pre_sel,
   input  logic [DATA_W-1:0] pre_data,
   output logic              a_drive,
   output logic              a_capture,
   output logic              b_drive,
   output logic              b_capture,
   output logic              s_drive,
   output logic              s_capture,
   output logic              done,
   output logic [DATA_W-1:0] bus,
   output logic [DATA_W-1:0] a_q,
   output logic [DATA_W-1:0] b_q,
   output logic [DATA_W-1:0] s_q
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("reg_swap_ctrl: DATA_W must be at least 1");
      end
      if (SEL_W != 2) begin : g_bad_sel
         $error("reg_swap_ctrl: preload select must be two bits");
      end
   endgenerate

   swap_ctl_t                       ctl;
   logic                            at_rest;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [NUM_REGS-1:0]             pre_hit;

   swap_state_reg #(
      .ONE_HOT (ONE_HOT)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ctl     (ctl),
      .at_rest (at_rest)
   );

   // select code k+1 addresses register k; code 0 addresses none
   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_pre
         assign pre_hit[g] = pre_en & at_rest & (pre_sel == SEL_W'(g + 1));
      end
   endgenerate

   swap_bus_mux #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_REGS)
   ) u_bus (
      .src   (regs),
      .drive (drive_vec(ctl)),
      .bus   (bus)
   );

   swap_regfile #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus      (bus),
      .capture  (capture_vec(ctl)),
      .preload  (pre_hit),
      .pre_data (pre_data),
      .q        (regs)
   );

   assign a_drive   = ctl.a_drive;
   assign a_capture = ctl.a_capture;
   assign b_drive   = ctl.b_drive;
   assign b_capture = ctl.b_capture;
   assign s_drive   = ctl.s_drive;
   assign s_capture = ctl.s_capture;
   assign done      = ctl.done;

   assign a_q = regs[IDX_A];
   assign b_q = regs[IDX_B];
   assign s_q = regs[IDX_S];

endmodule

// File: rtl/reg_swap_ctrl_checker.sv
module reg_swap_ctrl_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              a_drive,
   input logic              a_capture,
   input logic              b_drive,
   input logic              b_capture,
   input logic              s_drive,
   input logic              s_capture,
   input logic              done,
   input logic [DATA_W-1:0] bus,
   input logic [DATA_W-1:0] a_q,
   input logic [DATA_W-1:0] b_q,
   input logic [DATA_W-1:0] s_q
);

   logic quiet;
   assign quiet = !(a_drive || b_drive || s_drive || a_capture || b_capture || s_capture || done);

   assert_single_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({a_drive, b_drive, s_drive}) <= 1);

   assert_single_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({a_capture, b_capture, s_capture}) <= 1);

   assert_rest_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !start) |=> quiet);

   assert_first_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && start) |=> (b_drive && s_capture));

   assert_scratch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      s_capture |=> (s_q == $past(b_q)));

   assert_second_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (b_drive && s_capture) |=> (a_drive && b_capture));

   assert_third_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drive && b_capture) |=> (s_drive && a_capture && done));

   assert_done_only_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (s_drive && a_capture));

   assert_back_to_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> quiet);

   assert_bus_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> (bus == '0));

   assert_a_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!quiet && !a_capture) |=> (a_q == $past(a_q)));

endmodule

bind reg_swap_ctrl reg_swap_ctrl_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .a_drive   (a_drive),
   .a_capture (a_capture),
   .b_drive   (b_drive),
   .b_capture (b_capture),
   .s_drive   (s_drive),
   .s_capture (s_capture),
   .done      (done),
   .bus       (bus),
   .a_q       (a_q),
   .b_q       (b_q),
   .s_q       (s_q)
);

// File: tb/reg_swap_ctrl_bench.sv
module reg_swap_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int NVEC       = 21;
   localparam int VW         = 55;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          pre_en = 1'b0;
   logic [1:0]    pre_sel = 2'd0;
   logic [DW-1:0] pre_data = '0;

   logic          ad0, ac0, bd0, bc0, sd0, sc0, dn0;
   logic [DW-1:0] bus0, a0, b0, s0;
   logic          ad1, ac1, bd1, bc1, sd1, sc1, dn1;
   logic [DW-1:0] bus1, a1, b1, s1;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   reg_swap_ctrl #(.DATA_W(DW), .ONE_HOT(1'b0)) u_reg_swap_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .pre_en(pre_en), .pre_sel(pre_sel),
      .pre_data(pre_data), .a_drive(ad0), .a_capture(ac0), .b_drive(bd0), .b_capture(bc0),
      .s_drive(sd0), .s_capture(sc0), .done(dn0), .bus(bus0), .a_q(a0), .b_q(b0), .s_q(s0)
   );

   reg_swap_ctrl #(.DATA_W(DW), .ONE_HOT(1'b1)) u_reg_swap_ctrl_oh (
      .clk(clk), .rst_n(rst_n), .start(start), .pre_en(pre_en), .pre_sel(pre_sel),
      .pre_data(pre_data), .a_drive(ad1), .a_capture(ac1), .b_drive(bd1), .b_capture(bc1),
      .s_drive(sd1), .s_capture(sc1), .done(dn1), .bus(bus1), .a_q(a1), .b_q(b1), .s_q(s1)
   );

   // vector: {req, start, pre_en, pre_sel, pre_data, ctl, bus, a, b, s}
   // ctl bit order {a_drive, a_capture, b_drive, b_capture, s_drive, s_capture, done}
   // 7'h12 = B to scratch, 7'h48 = A to B, 7'h25 = scratch to A with done
   localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
      {4'd9, 1'b0, 1'b1, 2'd1, 8'h11, 7'h00, 8'h00, 8'h11, 8'h00, 8'h00}, // R9 preload A
      {4'd9, 1'b0, 1'b1, 2'd2, 8'h22, 7'h00, 8'h00, 8'h11, 8'h22, 8'h00}, // R9 preload B
      {4'd9, 1'b0, 1'b1, 2'd3, 8'h33, 7'h00, 8'h00, 8'h11, 8'h22, 8'h33}, // R9 preload scratch
      {4'd3, 1'b1, 1'b0, 2'd0, 8'h00, 7'h12, 8'h22, 8'h11, 8'h22, 8'h33}, // R3 start
      {4'd9, 1'b0, 1'b1, 2'd1, 8'hEE, 7'h48, 8'h11, 8'h11, 8'h22, 8'h22}, // R9 preload while busy ignored
      {4'd5, 1'b0, 1'b0, 2'd0, 8'h00, 7'h25, 8'h22, 8'h11, 8'h11, 8'h22}, // R5 last step
      {4'd6, 1'b0, 1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h22, 8'h11, 8'h22}, // R6 swapped, rest
      {4'd2, 1'b0, 1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h22, 8'h11, 8'h22}, // R2 hold
      {4'd3, 1'b1, 1'b0, 2'd0, 8'h00, 7'h12, 8'h11, 8'h22, 8'h11, 8'h22}, // R3 start held
      {4'd4, 1'b1, 1'b0, 2'd0, 8'h00, 7'h48, 8'h22, 8'h22, 8'h11, 8'h11}, // R4
      {4'd5, 1'b1, 1'b0, 2'd0, 8'h00, 7'h25, 8'h11, 8'h22, 8'h22, 8'h11}, // R5
      {4'd6, 1'b1, 1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h11, 8'h22, 8'h11}, // R6 rest despite start
      {4'd6, 1'b1, 1'b0, 2'd0, 8'h00, 7'h12, 8'h22, 8'h11, 8'h22, 8'h11}, // R6 restart after 4 cycles
      {4'd4, 1'b0, 1'b0, 2'd0, 8'h00, 7'h48, 8'h11, 8'h11, 8'h22, 8'h22}, // R4
      {4'd5, 1'b0, 1'b0, 2'd0, 8'h00, 7'h25, 8'h22, 8'h11, 8'h11, 8'h22}, // R5
      {4'd6, 1'b0, 1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h22, 8'h11, 8'h22}, // R6
      {4'd9, 1'b0, 1'b1, 2'd0, 8'hFF, 7'h00, 8'h00, 8'h22, 8'h11, 8'h22}, // R9 select 0 writes none
      {4'd9, 1'b1, 1'b1, 2'd3, 8'h5A, 7'h12, 8'h11, 8'h22, 8'h11, 8'h5A}, // R9 preload with start
      {4'd7, 1'b0, 1'b0, 2'd0, 8'h00, 7'h48, 8'h22, 8'h22, 8'h11, 8'h11}, // R7 bus from A
      {4'd7, 1'b0, 1'b0, 2'd0, 8'h00, 7'h25, 8'h11, 8'h22, 8'h22, 8'h11}, // R7 bus from scratch
      {4'd7, 1'b0, 1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h11, 8'h22, 8'h11}  // R7 bus zero at rest
   };

   function automatic string rname(input int n);
      case (n)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         10: return "R10";
         11: return "R11";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic [6:0] ctl, input logic [DW-1:0] b,
                            input logic [DW-1:0] ea, input logic [DW-1:0] eb, input logic [DW-1:0] es);
      logic [6:0] ctl0, ctl1;
      ctl0 = {ad0, ac0, bd0, bc0, sd0, sc0, dn0};
      ctl1 = {ad1, ac1, bd1, bc1, sd1, sc1, dn1};
      check(req, "enables", 32'(ctl0), 32'(ctl));
      check("R7", "bus", 32'(bus0), 32'(b));
      check(req, "reg A", 32'(a0), 32'(ea));
      check(req, "reg B", 32'(b0), 32'(eb));
      check(req, "scratch", 32'(s0), 32'(es));
      check("R8", "drive count", 32'($countones({ad0, bd0, sd0}) <= 1), 32'd1);
      check("R10", "one-hot enables", 32'(ctl1), 32'(ctl0));
      check("R10", "one-hot data", {8'h0, bus1, a1, b1 ^ s1}, {8'h0, bus0, a0, b0 ^ s0});
   endtask

   task automatic step(input logic st, input logic pe, input logic [1:0] ps, input logic [DW-1:0] pd);
      start    = st;
      pre_en   = pe;
      pre_sel  = ps;
      pre_data = pd;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state, with preload and start attempted during reset
      step(1'b1, 1'b1, 2'd1, 8'h77);
      step(1'b1, 1'b1, 2'd1, 8'h77);
      check_all("R1", 7'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      start  = 1'b0;
      pre_en = 1'b0;
      rst_n  = 1'b1;
      step(1'b0, 1'b0, 2'd0, 8'h00);
      check_all("R1", 7'h00, 8'h00, 8'h00, 8'h00, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         step(v[50], v[49], v[48:47], v[46:39]);
         check_all(rname(int'(v[54:51])), v[38:32], v[31:24], v[23:16], v[15:8], v[7:0]);
      end

      // R11 reset in the middle of a swap
      step(1'b1, 1'b0, 2'd0, 8'h00);
      step(1'b0, 1'b0, 2'd0, 8'h00);
      check_all("R4", 7'h48, 8'h11, 8'h11, 8'h22, 8'h22);
      #2;
      rst_n = 1'b0;
      #1;
      check_all("R11", 7'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      step(1'b0, 1'b0, 2'd0, 8'h00);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 2'd0, 8'h00);
      check_all("R11", 7'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      step(1'b1, 1'b0, 2'd0, 8'h00);
      check_all("R11", 7'h12, 8'h00, 8'h00, 8'h00, 8'h00);
      step(1'b0, 1'b0, 2'd0, 8'h00);
      step(1'b0, 1'b0, 2'd0, 8'h00);
      step(1'b0, 1'b0, 2'd0, 8'h00);
      check_all("R6", 7'h00, 8'h00, 8'h00, 8'h00, 8'h00);

      finish_run();
   end

endmodule